// File: doc/BRIEF.md
# Carry-Aware Integer ALU with Condition Select

This block is the arithmetic-logic stage of a pipelined execution datapath. Each cycle where `op_valid` is high, it takes two 32-bit operands, a 4-bit operation code and a 4-bit condition selector. One clock edge later it presents a registered result and a registered condition bit. A single carry flag persists between operations. Some add flavours write this flag, one consumes it, and logic operations never touch it.

There are three adds. The plain add ignores the flag and leaves it alone. The carry-setting add starts from a zero carry-in and records the carry-out. The carry-consuming add uses the stored flag as its carry-in and records the new carry-out. Subtraction is computed as `left + ~right + 1` and stores its carry-out, so a stored 1 means no borrow. The condition selector reports one property of the result just produced: zero, negative, the carry or a constant. Multi-word arithmetic can therefore be chained, and branch decisions can be taken from the registered condition.

Top module: `alu_exec`

## Requirements
- R1: When `op_valid` is high at a rising clock edge, `result_q` and `cond_q` show the outcome of that operation from that edge onward and `res_valid` is 1; when `op_valid` is low, `res_valid` is 0 at the next edge, and `result_q` and `carry_q` keep their values.
- R2: While `rst_n` is low, `result_q`, `cond_q`, `carry_q` and `res_valid` are 0, whatever the other inputs are.
- R3: Op codes 0, 1 and 2 give left OR right, left AND right and left XOR right, and leave `carry_q` unchanged.
- R4: Op code 3 (plain add) gives left + right modulo 2^32 with a carry-in of 0, and leaves `carry_q` unchanged.
- R5: Op code 4 (subtract) gives left + ~right + 1 modulo 2^32, and sets `carry_q` to the carry-out of that sum (1 when left >= right unsigned).
- R6: Op code 5 (carry-setting add) gives left + right with a carry-in of 0, and sets `carry_q` to its carry-out.
- R7: Op code 6 (carry-consuming add) gives left + right + `carry_q`, and sets `carry_q` to its carry-out.
- R8: Op codes 7 to 15 give a result of 0 and leave `carry_q` unchanged.
- R9: Condition select 0 gives `cond_q` = 0, select 1 gives `cond_q` = 1, and selects 8 to 15 give `cond_q` = 0.
- R10: Condition select 2 gives 1 exactly when the result is zero, and select 3 gives 1 exactly when it is non-zero.
- R11: Condition select 4 gives result bit 31 (negative), and select 5 gives its inverse (greater than or equal to zero).
- R12: Condition select 6 gives the carry flag as it stands after the operation, and select 7 gives its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (R3 to R8) |
| cond_sel | input | 4 | Condition selector (R9 to R12) |
| left_opnd | input | 32 | Left operand |
| right_opnd | input | 32 | Right operand |
| res_valid | output | 1 | Registered result and condition are fresh |
| result_q | output | 32 | Registered result |
| cond_q | output | 1 | Registered selected condition |
| carry_q | output | 1 | Stored carry flag |

## Verification
Small directed operand pairs pin each operation to a known answer: 12 + 73, 10 and 3 for the logic operations, 47 - 31, and 2 - 3 giving all ones. Each pair with a different op code tells the operations apart. Pairs that overflow (0xFFFFFFFF + 1) or borrow separate the three add flavours by the carry each leaves behind. A carry-consuming add placed after a set carry and after a cleared carry proves the flag is really consumed. Equal, unequal and sign-crossing subtractions drive the zero, negative and carry conditions to both polarities, and a pseudo-random stream over all op codes and selectors mixes logic ops between carry writers to catch a flag that is disturbed when it should hold.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned SEL_W = 4;

  localparam logic [OPC_W-1:0] OPC_OR   = 4'd0;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_XOR  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LADD = 4'd5;
  localparam logic [OPC_W-1:0] OPC_CADD = 4'd6;

  localparam logic [SEL_W-1:0] CSEL_FALSE = 4'd0;
  localparam logic [SEL_W-1:0] CSEL_TRUE  = 4'd1;
  localparam logic [SEL_W-1:0] CSEL_EZ    = 4'd2;
  localparam logic [SEL_W-1:0] CSEL_NZ    = 4'd3;
  localparam logic [SEL_W-1:0] CSEL_LZ    = 4'd4;
  localparam logic [SEL_W-1:0] CSEL_GEZ   = 4'd5;
  localparam logic [SEL_W-1:0] CSEL_CY    = 4'd6;
  localparam logic [SEL_W-1:0] CSEL_NCY   = 4'd7;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_STORE = 2'd2
  } cin_src_e;

  typedef struct packed {
    logic     is_arith;
    logic     invert_r;
    logic     carry_wr;
    cin_src_e cin_src;
  } op_ctl_t;

  function automatic op_ctl_t decode_op(input logic [OPC_W-1:0] opc);
    op_ctl_t c;
    c = '{is_arith: 1'b0, invert_r: 1'b0, carry_wr: 1'b0, cin_src: CIN_ZERO};
    case (opc)
      OPC_ADD:  c.is_arith = 1'b1;
      OPC_SUB:  begin c.is_arith = 1'b1; c.invert_r = 1'b1; c.carry_wr = 1'b1; c.cin_src = CIN_ONE; end
      OPC_LADD: begin c.is_arith = 1'b1; c.carry_wr = 1'b1; end
      OPC_CADD: begin c.is_arith = 1'b1; c.carry_wr = 1'b1; c.cin_src = CIN_STORE; end
      default:  c.is_arith = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned EXT_W = W + 1;

  function automatic logic [EXT_W-1:0] add_ext(input logic [W-1:0] x,
                                               input logic [W-1:0] y,
                                               input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0]     b_eff;
  logic [EXT_W-1:0] total;

  assign b_eff = invert_b ? ~b_in : b_in;
  assign total = add_ext(a_in, b_eff, cin);
  assign sum   = total[W-1:0];
  assign cout  = total[EXT_W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_exec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     y
);
  always_comb begin
    case (opc)
      OPC_OR:  y = a_in | b_in;
      OPC_AND: y = a_in & b_in;
      OPC_XOR: y = a_in ^ b_in;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_exec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     res,
  input  logic             carry,
  output logic             cond
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (res == '0);
  assign is_neg  = res[W-1];

  always_comb begin
    case (sel)
      CSEL_TRUE: cond = 1'b1;
      CSEL_EZ:   cond = is_zero;
      CSEL_NZ:   cond = !is_zero;
      CSEL_LZ:   cond = is_neg;
      CSEL_GEZ:  cond = !is_neg;
      CSEL_CY:   cond = carry;
      CSEL_NCY:  cond = !carry;
      default:   cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [OPC_W-1:0]   op_code,
  input  logic [SEL_W-1:0]   cond_sel,
  input  logic [DATA_W-1:0]  left_opnd,
  input  logic [DATA_W-1:0]  right_opnd,
  output logic               res_valid,
  output logic [DATA_W-1:0]  result_q,
  output logic               cond_q,
  output logic               carry_q
);
  op_ctl_t            ctl;
  logic               add_cin;
  logic [DATA_W-1:0]  add_sum;
  logic               add_cout;
  logic [DATA_W-1:0]  logic_y;
  logic [DATA_W-1:0]  res_next;
  logic               carry_next;
  logic               cond_next;
  logic               carry_wr;

  assign ctl = decode_op(op_code);

  always_comb begin
    case (ctl.cin_src)
      CIN_ONE:   add_cin = 1'b1;
      CIN_STORE: add_cin = carry_q;
      default:   add_cin = 1'b0;
    endcase
  end

  alu_adder #(.W(DATA_W)) u_add (
    .a_in     (left_opnd),
    .b_in     (right_opnd),
    .invert_b (ctl.invert_r),
    .cin      (add_cin),
    .sum      (add_sum),
    .cout     (add_cout)
  );

  alu_logic_unit #(.W(DATA_W)) u_logic (
    .opc  (op_code),
    .a_in (left_opnd),
    .b_in (right_opnd),
    .y    (logic_y)
  );

  assign res_next   = ctl.is_arith ? add_sum : logic_y;
  assign carry_wr   = op_valid && ctl.carry_wr;
  assign carry_next = ctl.carry_wr ? add_cout : carry_q;

  alu_cond_eval #(.W(DATA_W)) u_cond (
    .sel   (cond_sel),
    .res   (res_next),
    .carry (carry_next),
    .cond  (cond_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result_q  <= '0;
      cond_q    <= 1'b0;
      carry_q   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result_q <= res_next;
        cond_q   <= cond_next;
      end
      if (carry_wr) carry_q <= carry_next;
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_exec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OPC_W-1:0] op_code,
  input logic [SEL_W-1:0] cond_sel,
  input logic [W-1:0]     left_opnd,
  input logic [W-1:0]     right_opnd,
  input logic             res_valid,
  input logic [W-1:0]     result_q,
  input logic             cond_q,
  input logic             carry_q,
  input logic             carry_wr
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(result_q)));

  a_r3_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_wr |=> $stable(carry_q));

  a_r3_or_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_OR) |=> result_q == ($past(left_opnd) | $past(right_opnd)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > OPC_CADD) |=> result_q == '0);

  a_r9_false_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_sel == CSEL_FALSE) |=> !cond_q);

  a_r10_zero_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_sel == CSEL_EZ) |=> cond_q == (result_q == '0));

  a_r11_neg_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_sel == CSEL_LZ) |=> cond_q == result_q[W-1]);

  a_r12_carry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_sel == CSEL_CY) |=> cond_q == carry_q);
endmodule

bind alu_exec alu_exec_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .cond_sel   (cond_sel),
  .left_opnd  (left_opnd),
  .right_opnd (right_opnd),
  .res_valid  (res_valid),
  .result_q   (result_q),
  .cond_q     (cond_q),
  .carry_q    (carry_q),
  .carry_wr   (carry_wr)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [3:0]  cond_sel = 4'd0;
  logic [31:0] left_opnd = '0;
  logic [31:0] right_opnd = '0;
  logic        res_valid;
  logic [31:0] result_q;
  logic        cond_q;
  logic        carry_q;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        cond;
    logic        carry;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic        mdl_carry = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always #4 clk = ~clk;

  alu_exec u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cond_sel(cond_sel), .left_opnd(left_opnd), .right_opnd(right_opnd),
    .res_valid(res_valid), .result_q(result_q), .cond_q(cond_q), .carry_q(carry_q)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [3:0] op, input logic [3:0] sel,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic c);
    logic [32:0] wide;
    case (op)
      4'd0: r = a | b;
      4'd1: r = a & b;
      4'd2: r = a ^ b;
      4'd3: r = a + b;
      4'd4: begin r = a - b; mdl_carry = (a >= b); end
      4'd5: begin wide = 33'(a) + 33'(b); r = wide[31:0]; mdl_carry = wide[32]; end
      4'd6: begin wide = 33'(a) + 33'(b) + 33'(mdl_carry); r = wide[31:0]; mdl_carry = wide[32]; end
      default: r = 32'd0;
    endcase
    case (sel)
      4'd1: c = 1'b1;
      4'd2: c = (r == 0);
      4'd3: c = (r != 0);
      4'd4: c = r[31];
      4'd5: c = !r[31];
      4'd6: c = mdl_carry;
      4'd7: c = !mdl_carry;
      default: c = 1'b0;
    endcase
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] sel,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; cond_sel = sel; left_opnd = a; right_opnd = b;
    model(op, sel, a, b, e.res, e.cond);
    e.carry = mdl_carry;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Monitor: compares each fresh result against the queue head
  always @(negedge clk) begin
    if (rst_n && res_valid && !done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected result", result_q, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result_q == e.res, {e.tag, " result"}, result_q, e.res);
        check(cond_q == e.cond, {e.tag, " cond"}, 32'(cond_q), 32'(e.cond));
        check(carry_q == e.carry, {e.tag, " carry"}, 32'(carry_q), 32'(e.carry));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: reset with busy inputs
    op_valid = 1'b1; op_code = 4'd5; cond_sel = 4'd1; left_opnd = '1; right_opnd = 32'd1;
    repeat (3) @(negedge clk);
    check(result_q == 0 && cond_q == 0 && carry_q == 0 && res_valid == 0,
          "R2 reset state", {result_q[31:3], cond_q, carry_q, res_valid}, 32'd0);
    op_valid = 1'b0;
    rst_n = 1'b1;

    drive(4'd5, 4'd2, 32'd12, 32'd73, "R6 carry-setting add");
    drive(4'd6, 4'd7, 32'd12, 32'd73, "R7 carry-consuming add cy0");
    drive(4'd4, 4'd4, 32'd2, 32'd3, "R5 R11 sub negative");
    drive(4'd4, 4'd2, 32'd2, 32'd2, "R5 R10 sub zero");
    drive(4'd6, 4'd6, 32'd5, 32'd6, "R7 R12 add uses carry 1");
    drive(4'd4, 4'd5, 32'd47, 32'd31, "R5 R11 sub 47-31");
    drive(4'd5, 4'd6, 32'hFFFF_FFFF, 32'd1, "R6 R12 carry-setting overflow");
    drive(4'd0, 4'd3, 32'd10, 32'd3, "R3 R10 or");
    drive(4'd1, 4'd1, 32'd10, 32'd3, "R3 R9 and");
    drive(4'd2, 4'd9, 32'd10, 32'd3, "R3 R9 xor");
    drive(4'd3, 4'd2, 32'hFFFF_FFFF, 32'd1, "R4 plain add wrap");
    drive(4'd3, 4'd0, 32'd12, 32'd73, "R4 R9 plain add");
    drive(4'd9, 4'd2, 32'h1234_5678, 32'h0F0F_0F0F, "R8 reserved op");
    drive(4'd15, 4'd7, 32'd0, 32'd0, "R8 R12 reserved op top");
    drive(4'd6, 4'd4, 32'h7FFF_FFFF, 32'd0, "R7 R11 add carry into sign");
    drive(4'd4, 4'd6, 32'd1, 32'd2, "R5 R12 sub borrow");

    // R1: idle cycle with a carry-writing op on the inputs must change nothing
    drive(4'd5, 4'd1, 32'hFFFF_FFFF, 32'd1, "R6 set carry before idle");
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd4; left_opnd = 32'd0; right_opnd = 32'd1; cond_sel = 4'd0;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 idle valid low", 32'(res_valid), 32'd0);
    check(result_q == 32'd0 && carry_q == 1'b1, "R1 idle holds result and carry",
          {result_q[31:1], carry_q}, 32'd1);

    for (int i = 0; i < 60; i++) begin
      logic [3:0] op;
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = (lfsr[7:4] < 4'd14) ? 4'(lfsr[7:4] % 7) : lfsr[7:4];
      drive(op, lfsr[11:8], a, (lfsr[12] ? lfsr : a), "R1 random stream");
    end
    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 all results seen", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule